// File: doc/BRIEF.md
# Edge-to-Edge Interval Capture

This block measures how long an external signal takes between two consecutive qualifying edges. The input is first brought into the clock domain by a synchronizer. Each synchronized transition is then qualified against a programmable edge type: rising only, falling only, or both. A running counter adds one for every timebase tick. The timebase is either the clock itself or a tick-enable strobe that an external prescaler supplies.

The first qualifying edge arms the block and clears the counter. Every later qualifying edge latches the elapsed tick count into the capture register and pulses a capture flag. It also restarts the counter, so a stream of edges gives one interval after another with no dead time. The counter saturates instead of wrapping, which makes an over-long interval read as the largest value. Capture runs only while the global enable, the timer enable and the capture enable are all high and the timebase selector holds a code from 0 to 8. At any other time the block falls back to idle and keeps its last result.

Top module: `edge_interval_capture`

## Requirements
- R1: After a synchronous reset, `cap_count` is 0, `cap_flag` is 0 and `cap_valid` is 0.
- R2: With `edge_sel` = 1, only rising edges of `evt_in` qualify. With `src_sel` = 8, a tick occurs on every clock, so the captured value equals the number of clock cycles between the two rising edges.
- R3: With `edge_sel` = 2, only falling edges qualify. With `edge_sel` = 3, both kinds of edge qualify. With `edge_sel` = 0, no edge qualifies, and neither `cap_flag` nor `cap_count` changes.
- R4: The first qualifying edge after the block leaves idle only arms it. It raises no flag and leaves `cap_valid` and `cap_count` unchanged.
- R5: On every qualifying edge after the first, `cap_count` takes the tick count, `cap_flag` is high for that one cycle and `cap_valid` becomes 1 and stays 1 until reset. The counter restarts, so consecutive edges yield consecutive intervals, down to a spacing of one clock.
- R6: With `src_sel` from 0 to 7, only cycles with `tick_en` high are counted. If `tick_en` is held low, the capture is 0.
- R7: With `src_sel` from 9 to 15, with `tmr_en` low or with `glb_en` low, no capture takes place.
- R8: Lowering `cap_en` returns the block to idle and leaves `cap_count` unchanged. After capture is re-enabled, the first qualifying edge only arms the block.
- R9: The tick counter saturates at 2^`CNT_W`-1. An interval longer than that is captured as 2^`CNT_W`-1.
- R10: `cap_flag` rises on the third rising clock edge after a change of `evt_in` that is set up before the first of those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| glb_en | input | 1 | Global enable |
| tmr_en | input | 1 | Timer enable |
| cap_en | input | 1 | Capture enable; low forces idle |
| src_sel | input | 4 | Timebase: 0-7 use tick_en, 8 counts every clock, 9-15 inactive |
| tick_en | input | 1 | Prescaled tick strobe |
| edge_sel | input | 2 | Qualifying edges: 0 none, 1 rising, 2 falling, 3 both |
| evt_in | input | 1 | Asynchronous event input |
| cap_count | output | CNT_W | Last captured interval, in ticks |
| cap_flag | output | 1 | One-cycle pulse on each new capture |
| cap_valid | output | 1 | A capture has completed since reset |

## Verification
The bench drives edges only one clock apart in both-edges mode. A counter that does not restart on the capturing edge, or that drops the tick of that cycle, would report 0 or 2 instead of 1. The bench turns capture off while the block is armed and then turns it back on. A design that stays armed would then report a stale, very long interval where none is expected. The bench also runs an interval longer than the counter range, which would expose a counter that wraps to a small value. It toggles the input under edge type 0, under an inactive timebase code and with each enable low, so any stray flag or change of the held capture is caught.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int EIC_SRC_W = 4;
  localparam logic [EIC_SRC_W-1:0] EIC_SRC_CLK = 4'd8;

  typedef enum logic [1:0] {
    EIC_IDLE  = 2'd0,
    EIC_ARMED = 2'd1,
    EIC_DONE  = 2'd2
  } eic_state_t;
endpackage

// File: rtl/eic_edge_det.sv
module eic_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  // sh[STAGES-1] is the synchronized sample, sh[STAGES] the previous one
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/eic_counter.sv
module eic_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_upd
);
  localparam logic [W-1:0] MAXV = '1;

  // Saturating next value; also the value latched on a capturing edge
  assign cnt_upd = (tick && cnt != MAXV) ? cnt + 1'b1 : cnt;

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (clr) cnt <= '0;
    else if (run) cnt <= cnt_upd;
  end
endmodule

// File: rtl/eic_ctrl.sv
module eic_ctrl
  import eic_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic         qual,
  input  logic [W-1:0] cnt_upd,
  output eic_state_t   state,
  output logic [W-1:0] cap_count,
  output logic         cap_flag,
  output logic         cap_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= EIC_IDLE;
      cap_count <= '0;
      cap_flag  <= 1'b0;
      cap_valid <= 1'b0;
    end else begin
      cap_flag <= 1'b0;
      if (!active) begin
        state <= EIC_IDLE;
      end else if (qual) begin
        if (state == EIC_IDLE) begin
          state <= EIC_ARMED;
        end else begin
          cap_count <= cnt_upd;
          cap_flag  <= 1'b1;
          cap_valid <= 1'b1;
          state     <= EIC_DONE;
        end
      end
    end
  end
endmodule

// File: rtl/edge_interval_capture.sv
module edge_interval_capture
  import eic_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 glb_en,
  input  logic                 tmr_en,
  input  logic                 cap_en,
  input  logic [EIC_SRC_W-1:0] src_sel,
  input  logic                 tick_en,
  input  logic [1:0]           edge_sel,
  input  logic                 evt_in,
  output logic [CNT_W-1:0]     cap_count,
  output logic                 cap_flag,
  output logic                 cap_valid
);
  logic             rise, fall, active, qual, tick, run;
  logic [CNT_W-1:0] cnt_q, cnt_upd;
  eic_state_t       state;

  assign active = glb_en & tmr_en & cap_en & (src_sel <= EIC_SRC_CLK);
  assign qual   = active & ((edge_sel[0] & rise) | (edge_sel[1] & fall));
  assign tick   = (src_sel == EIC_SRC_CLK) | tick_en;
  assign run    = (state != EIC_IDLE);

  eic_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .din(evt_in), .rise(rise), .fall(fall)
  );

  eic_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(qual), .run(run), .tick(tick),
    .cnt(cnt_q), .cnt_upd(cnt_upd)
  );

  eic_ctrl #(.W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .active(active), .qual(qual), .cnt_upd(cnt_upd),
    .state(state), .cap_count(cap_count), .cap_flag(cap_flag),
    .cap_valid(cap_valid)
  );
endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             glb_en,
  input logic             tmr_en,
  input logic             cap_en,
  input logic [3:0]       src_sel,
  input logic [1:0]       edge_sel,
  input logic [CNT_W-1:0] cap_count,
  input logic             cap_flag,
  input logic             cap_valid,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  AST_FLAG_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
    cap_flag |-> cap_valid); // R5
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    cap_valid |=> cap_valid); // R5
  AST_HOLD_WITHOUT_FLAG: assert property (@(posedge clk) disable iff (rst)
    !cap_flag |-> $stable(cap_count)); // R5
  AST_NO_EDGE_TYPE: assert property (@(posedge clk) disable iff (rst)
    (edge_sel == 2'd0) |=> !cap_flag); // R3
  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(glb_en && tmr_en && src_sel <= 4'd8) |=> !cap_flag); // R7
  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> $stable(cap_count) && !cap_flag); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cnt == MAXV) |=> (cnt == MAXV) || (cnt == '0)); // R9
endmodule

bind edge_interval_capture eic_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .glb_en(glb_en), .tmr_en(tmr_en), .cap_en(cap_en),
  .src_sel(src_sel), .edge_sel(edge_sel), .cap_count(cap_count),
  .cap_flag(cap_flag), .cap_valid(cap_valid), .cnt(cnt_q)
);

// File: tb/edge_interval_capture_tb.sv
`timescale 1ns/1ps
module edge_interval_capture_tb;
  localparam int W = 10;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         glb_en = 1'b0, tmr_en = 1'b0, cap_en = 1'b0;
  logic [3:0]   src_sel = 4'd8;
  logic         tick_en = 1'b0;
  logic [1:0]   edge_sel = 2'd0;
  logic         evt_in = 1'b0;
  logic [W-1:0] cap_count;
  logic         cap_flag, cap_valid;

  int nchk = 0, nerr = 0, cyc = 0, tmode = 0;
  bit m_active = 0, m_armed = 0, finished = 0;
  int m_last = 0, m_rate = 0, last_cap = 0;
  string cur_req = "R2";
  int q[$];

  edge_interval_capture #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .glb_en(glb_en), .tmr_en(tmr_en), .cap_en(cap_en),
    .src_sel(src_sel), .tick_en(tick_en), .edge_sel(edge_sel), .evt_in(evt_in),
    .cap_count(cap_count), .cap_flag(cap_flag), .cap_valid(cap_valid)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tick_en <= (tmode == 1) && (cyc % 4 == 0);

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: every flag must match the next expected interval
  always @(negedge clk) begin
    if (!rst && cap_flag) begin
      if (q.size() == 0) chk(1'b0, {cur_req, " unexpected capture"}, int'(cap_count), -1);
      else begin
        int e;
        e = q.pop_front();
        chk(int'(cap_count) == e, cur_req, int'(cap_count), e);
      end
    end
  end

  function automatic int expv(int n);
    int v;
    v = (m_rate == 0) ? n : (m_rate == 1) ? n / 4 : 0;
    return (v > MAXV) ? MAXV : v;
  endfunction

  task automatic cfg(bit g, bit t, bit c, int s, int e, int tm);
    @(negedge clk);
    glb_en = g; tmr_en = t; cap_en = c; src_sel = s[3:0]; edge_sel = e[1:0];
    tmode = tm;
    m_active = g && t && c && (s <= 8);
    if (!m_active) m_armed = 0;
    m_rate = (s == 8) ? 0 : (tm == 1) ? 1 : 2;
    repeat (4) @(negedge clk);
  endtask

  // Driver: toggle the input, push the expected interval, then wait
  task automatic tog(int gap);
    bit qualifies;
    evt_in = ~evt_in;
    qualifies = m_active && (evt_in ? edge_sel[0] : edge_sel[1]);
    if (qualifies) begin
      if (m_armed) begin
        last_cap = expv(cyc - m_last);
        q.push_back(last_cap);
      end
      m_armed = 1;
      m_last = cyc;
    end
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cap_count == 0, "R1 count", int'(cap_count), 0);
    chk(cap_flag == 0, "R1 flag", int'(cap_flag), 0);
    chk(cap_valid == 0, "R1 valid", int'(cap_valid), 0);

    // R2 rising edges on the clock timebase, plus R4 and R10
    cur_req = "R2";
    cfg(1, 1, 1, 8, 1, 0);
    tog(10);
    chk(cap_valid == 0, "R4 valid after arming", int'(cap_valid), 0);
    chk(cap_count == 0, "R4 count after arming", int'(cap_count), 0);
    tog(7); tog(12); tog(5); tog(9); tog(6);
    tog(0);
    repeat (2) @(negedge clk);
    chk(cap_flag == 0, "R10 flag before third edge", int'(cap_flag), 0);
    @(negedge clk);
    chk(cap_flag == 1, "R10 flag on third edge", int'(cap_flag), 1);
    repeat (6) @(negedge clk);
    chk(cap_valid == 1, "R5 valid sticky", int'(cap_valid), 1);

    // R3 falling edges
    cur_req = "R3";
    cfg(1, 1, 0, 8, 2, 0);
    cfg(1, 1, 1, 8, 2, 0);
    tog(8); tog(4); tog(11); tog(3); tog(3); tog(6);

    // R3 / R5 both edges, including one-cycle spacing
    cur_req = "R5";
    cfg(1, 1, 0, 8, 3, 0);
    cfg(1, 1, 1, 8, 3, 0);
    tog(5); tog(6); tog(3); tog(20); tog(1); tog(1); tog(8);

    // R3 edge type 0 qualifies nothing
    cur_req = "R3";
    cfg(1, 1, 0, 8, 0, 0);
    cfg(1, 1, 1, 8, 0, 0);
    tog(6); tog(6); tog(6); tog(6);
    chk(int'(cap_count) == last_cap, "R3 held with no edge type", int'(cap_count), last_cap);

    // R6 prescaled ticks
    cur_req = "R6";
    cfg(1, 1, 0, 3, 3, 1);
    cfg(1, 1, 1, 3, 3, 1);
    tog(8); tog(12); tog(4); tog(16); tog(8);
    cfg(1, 1, 0, 0, 3, 0);
    cfg(1, 1, 1, 0, 3, 0);
    tog(8); tog(8); tog(8);
    chk(cap_count == 0, "R6 no ticks gives zero", int'(cap_count), 0);

    // R7 inactive settings
    cur_req = "R7";
    cfg(1, 1, 1, 9, 3, 0);
    tog(6); tog(6); tog(6);
    chk(int'(cap_count) == last_cap, "R7 source 9", int'(cap_count), last_cap);
    cfg(1, 0, 1, 8, 3, 0);
    tog(6); tog(6); tog(6);
    chk(int'(cap_count) == last_cap, "R7 timer off", int'(cap_count), last_cap);
    cfg(0, 1, 1, 8, 3, 0);
    tog(6); tog(6); tog(6);
    chk(int'(cap_count) == last_cap, "R7 global off", int'(cap_count), last_cap);

    // R8 capture enable cleared while armed
    cur_req = "R8";
    cfg(1, 1, 1, 8, 3, 0);
    tog(10); tog(7);
    cfg(1, 1, 0, 8, 3, 0);
    chk(int'(cap_count) == 10, "R8 value kept", int'(cap_count), 10);
    tog(5); tog(5);
    cfg(1, 1, 1, 8, 3, 0);
    tog(9);
    chk(int'(cap_count) == 10, "R8 first edge only arms", int'(cap_count), 10);
    tog(6);

    // R9 saturation
    cur_req = "R9";
    cfg(1, 1, 0, 8, 3, 0);
    cfg(1, 1, 1, 8, 3, 0);
    tog(1500); tog(20); tog(5);

    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R5 all expected captures seen", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    finished = 1;
    $finish;
  end
endmodule